// File: doc/BRIEF.md
# Bit-Slice ALU with Status Flags

This block is a small arithmetic logic unit assembled from a chain of identical one-bit slices. Each slice combines one bit of each operand with an incoming carry. It presents either the OR, the AND or the adder output of those bits on its result line, and it passes its carry to the next slice up. The adder is shared by addition and subtraction. For subtraction a control strobe inverts every bit of the second operand and forces the lowest carry in to one, so the slices compute A + ~B + 1.

A thin top level holds a decoder, which turns the 2-bit function select into a small set of strobes, and a datapath, which holds the slice chain and the flag logic. The result, the zero, negative and signed-overflow flags and a signed set-less-than bit are all captured in registers. They appear one clock after the operands and the select are presented. Operand width is a parameter with a default of four bits.

Top module: `bitslice_alu`

## Requirements
- R1: With funcSel = 2'b00 the result is the bitwise OR of opA and opB.
- R2: With funcSel = 2'b01 the result is the bitwise AND of opA and opB.
- R3: With funcSel = 2'b10 the result is (opA + opB) modulo 2^WIDTH, with the lowest carry in held at 0.
- R4: With funcSel = 2'b11 the result is (opA + ~opB + 1) modulo 2^WIDTH, that is opA − opB.
- R5: zero is 1 exactly when every bit of the registered result is 0.
- R6: negative equals the most significant bit of the registered result.
- R7: overflow is 1 when an add or subtract yields a two's-complement value outside the signed range, for example −8 − 1 and 7 − (−8) at WIDTH 4. It is always 0 for the OR and AND functions.
- R8: setLess is 1 when funcSel = 2'b11 and opA < opB as signed values, including when the subtraction overflows. It is 0 for every other select value.
- R9: All outputs are registered. They reflect the inputs sampled at the previous rising edge of clk. A synchronous active-low rstN drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| funcSel | input | 2 | Function: 00 OR, 01 AND, 10 add, 11 subtract |
| result | output | WIDTH | Registered result |
| zero | output | 1 | Registered result is all zeros |
| negative | output | 1 | Most significant bit of the registered result |
| overflow | output | 1 | Signed overflow of add or subtract |
| setLess | output | 1 | Signed opA < opB, valid for subtract |

## Verification
The hardest situation to reach is a subtraction whose difference overflows. In that case the sign bit of the difference gives the wrong answer, and setLess depends entirely on the overflow correction. Only a few operand pairs produce it, such as the most negative value minus one or the most positive value minus the most negative. The stimulus therefore walks every operand pair under every select value, so each overflow case is hit in both directions. It then replays the two extreme pairs as separately labelled checks and compares all five outputs against a behavioural signed-integer model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    FN_OR  = 2'b00,
    FN_AND = 2'b01,
    FN_ADD = 2'b10,
    FN_SUB = 2'b11
  } aluFunc_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic       invertB;   // complement every B bit ahead of the adder
    logic       carryIn0;  // carry into the lowest slice
    logic       arith;     // adder result is selected, overflow meaningful
    logic       lessEn;    // set-less-than is meaningful
    logic [1:0] muxSel;    // per-slice 4:1 output select
  } aluStrobes_t;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       aBit,
  input  logic       bBit,
  input  logic       invertB,
  input  logic       carryIn,
  input  logic [1:0] muxSel,
  output logic       resBit,
  output logic       carryOut
);

  logic bEff;
  logic sumBit;

  always_comb begin
    bEff     = bBit ^ invertB;
    sumBit   = aBit ^ bEff ^ carryIn;
    carryOut = (aBit & bEff) | (aBit & carryIn) | (bEff & carryIn);
    case (muxSel)
      FN_OR:   resBit = aBit | bBit;
      FN_AND:  resBit = aBit & bBit;
      FN_ADD:  resBit = sumBit;
      default: resBit = sumBit;
    endcase
  end

endmodule

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic [1:0]  funcSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.muxSel   = funcSel;
    strobes.arith    = funcSel[1];
    strobes.invertB  = (funcSel == FN_SUB);
    strobes.carryIn0 = (funcSel == FN_SUB);
    strobes.lessEn   = (funcSel == FN_SUB);
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] resD,
  output logic             zeroD,
  output logic             negD,
  output logic             ovfD,
  output logic             lessD
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;
  logic           msbCarryMismatch;

  assign carry[0] = strobes.carryIn0;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      alu_slice u_slice (
        .aBit     (opA[i]),
        .bBit     (opB[i]),
        .invertB  (strobes.invertB),
        .carryIn  (carry[i]),
        .muxSel   (strobes.muxSel),
        .resBit   (resD[i]),
        .carryOut (carry[i+1])
      );
    end
  endgenerate

  always_comb begin
    msbCarryMismatch = carry[WIDTH] ^ carry[MSB];
    zeroD = ~|resD;
    negD  = resD[MSB];
    ovfD  = strobes.arith & msbCarryMismatch;
    // sign of the difference, flipped back when it overflowed
    lessD = strobes.lessEn & (resD[MSB] ^ msbCarryMismatch);
  end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       funcSel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             negative,
  output logic             overflow,
  output logic             setLess
);

  localparam int MSB = WIDTH - 1;

  aluStrobes_t      strobes;
  logic [WIDTH-1:0] resD;
  logic             zeroD, negD, ovfD, lessD;

  alu_control u_control (
    .funcSel (funcSel),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .resD    (resD),
    .zeroD   (zeroD),
    .negD    (negD),
    .ovfD    (ovfD),
    .lessD   (lessD)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      zero     <= 1'b0;
      negative <= 1'b0;
      overflow <= 1'b0;
      setLess  <= 1'b0;
    end else begin
      result   <= resD;
      zero     <= zeroD;
      negative <= negD;
      overflow <= ovfD;
      setLess  <= lessD;
    end
  end

  // R7
  logic_no_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(funcSel[1])) |-> !overflow);

  // R8
  less_only_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && setLess) |-> ($past(funcSel) == FN_SUB));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    zero |-> (result == '0));

  // R3
  add_identity_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(funcSel) == FN_ADD && $past(opB) == '0)
      |-> (result == $past(opA) && !overflow));

  // R1
  or_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(funcSel) == FN_OR && $past(opB) == '1)
      |-> (result == '1 && negative && !zero));

  // R4
  sub_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(funcSel) == FN_SUB && $past(opA) == $past(opB))
      |-> (zero && !setLess && !overflow && !result[MSB]));

endmodule

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] opA, opB;
  logic [1:0]   funcSel;
  logic [W-1:0] result;
  logic         zero, negative, overflow, setLess;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitslice_alu #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .funcSel(funcSel),
    .result(result), .zero(zero), .negative(negative),
    .overflow(overflow), .setLess(setLess)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int toSigned(input int v);
    return (v >= MOD/2) ? v - MOD : v;
  endfunction

  // Drive one vector, wait for it to be registered, compare with model.
  task automatic runVec(input int a, input int b, input int s, input string note);
    int sa, sb, full, res, ovf, less;
    @(negedge clk);
    opA = a[W-1:0]; opB = b[W-1:0]; funcSel = s[1:0];
    @(negedge clk);
    sa = toSigned(a); sb = toSigned(b);
    ovf = 0; less = 0;
    case (s)
      0: res = a | b;
      1: res = a & b;
      2: begin
        full = sa + sb;
        res  = (a + b) % MOD;
        ovf  = (full > MOD/2 - 1 || full < -MOD/2) ? 1 : 0;
      end
      default: begin
        full = sa - sb;
        res  = (a - b + MOD) % MOD;
        ovf  = (full > MOD/2 - 1 || full < -MOD/2) ? 1 : 0;
        less = (sa < sb) ? 1 : 0;
      end
    endcase
    case (s)
      0: check({"R1 or ", note}, int'(result), res);
      1: check({"R2 and ", note}, int'(result), res);
      2: check({"R3 add ", note}, int'(result), res);
      default: check({"R4 sub ", note}, int'(result), res);
    endcase
    check({"R5 zero ", note}, int'(zero), (res == 0) ? 1 : 0);
    check({"R6 negative ", note}, int'(negative), (res >= MOD/2) ? 1 : 0);
    check({"R7 overflow ", note}, int'(overflow), ovf);
    check({"R8 setLess ", note}, int'(setLess), less);
  endtask

  task automatic checkResetState(input string note);
    check({"R9 reset result ", note}, int'(result), 0);
    check({"R9 reset zero ", note}, int'(zero), 0);
    check({"R9 reset negative ", note}, int'(negative), 0);
    check({"R9 reset overflow ", note}, int'(overflow), 0);
    check({"R9 reset setLess ", note}, int'(setLess), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; opA = '0; opB = '0; funcSel = 2'b00;
    repeat (3) @(negedge clk);
    checkResetState("initial");
    rstN = 1'b1;

    for (int s = 0; s < 4; s++)
      for (int a = 0; a < MOD; a++)
        for (int b = 0; b < MOD; b++)
          runVec(a, b, s, "sweep");

    // R7 R8 corner: -8 - 1 overflows positive, still less
    runVec(8, 1, 3, "corner -8-1");
    // R7 R8 corner: 7 - (-8) overflows negative, not less
    runVec(7, 8, 3, "corner 7-(-8)");
    // R7 add overflow both directions
    runVec(7, 1, 2, "corner 7+1");
    runVec(8, 15, 2, "corner -8+-1");

    // R9 reset while a nonzero result is held
    runVec(15, 15, 2, "before reset");
    @(negedge clk);
    rstN = 1'b0; opA = 4'd8; opB = 4'd1; funcSel = 2'b11;
    @(negedge clk);
    checkResetState("mid-run");
    rstN = 1'b1;
    runVec(3, 5, 3, "after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule